// File: doc/BRIEF.md
# Nibble-Multiplexed Transmit Word Assembler

This block takes transmit samples that arrive over a narrow 6-bit bus and rebuilds full 10-bit words for a downstream interpolator. Each word is split into two nibbles that are sent on consecutive cycles. A sync strobe tells the block which half of the word each nibble carries. A nibble sampled while sync is low opens a word. The next sample taken with sync high closes it. The rebuilt word is presented on a registered output together with a one-cycle valid strobe.

Static configuration inputs select four things. The first can swap which nibble is the most significant. The second can change the split from a 6/4 layout to a 5/5 layout. The third is a bypass mode in which every bus sample is a complete reduced-resolution 6-bit word. The fourth moves sampling of the bus and the sync strobe from the rising clock edge to the falling clock edge. A nibble always sits at the top of the bus, so a narrow nibble uses only the upper bus bits. If sync is held low, the last complete word is issued again on every cycle. This lets a source keep the downstream filter fed, for example with zeros.

Top module: `nib_word_asm`

## Requirements
- R1: While `rst_i` is high at a rising edge, the block clears `word_o` to zero and `valid_o` to 0, and it forgets any open first nibble. After reset it waits for a sync-low nibble.
- R2: The default configuration is 6/4 split with the most significant nibble first. In this configuration, a nibble F sampled with sync low and then a nibble S sampled with sync high on the next sample give `word_o = {F[5:0], S[5:2]}`. `valid_o` is 1 for one cycle after the rising edge that samples S. `S[1:0]` has no effect on the word.
- R3: With `cfg_ls_first_i` = 1 in the 6/4 split, the first nibble is the least significant part: `word_o = {S[5:0], F[5:2]}`.
- R4: With `cfg_even_split_i` = 1, each nibble supplies bits [5:1] of the bus. The most significant nibble forms `word_o[9:5]` and the least significant nibble forms `word_o[4:0]`. Bus bit 0 is ignored. The order follows `cfg_ls_first_i` in the same way as R2 and R3.
- R5: The output is registered. `word_o` and `valid_o` change only on a rising edge. They reflect the sample taken at that edge, or at the falling edge just before it.
- R6: A sync-high sample that has no open first nibble produces no valid strobe and leaves `word_o` unchanged. This covers a second consecutive sync-high sample and the first sync-high sample after reset.
- R7: A sync-low sample whose previous sample was also sync low makes `valid_o` 1 and keeps `word_o` unchanged, so the last word is repeated. The most recent sync-low nibble is the one that opens the next word.
- R8: With `cfg_bypass_i` = 1, every sample is a complete word. The block gives `word_o = {bus[5:0], 4'b0000}` and `valid_o` = 1 on every cycle. The sync level is ignored.
- R9: With `cfg_fall_edge_i` = 0, bus and sync are sampled at the rising edge. With `cfg_fall_edge_i` = 1, they are sampled at the falling edge that precedes the rising edge at which the output updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_fall_edge_i | input | 1 | 1: sample bus and sync on the falling edge |
| cfg_ls_first_i | input | 1 | 1: the first nibble of a word is the least significant part |
| cfg_even_split_i | input | 1 | 1: 5/5 split; 0: 6/4 split |
| cfg_bypass_i | input | 1 | 1: single-cycle 6-bit words, sync ignored |
| sync_i | input | 1 | Nibble sync: low for the first nibble, high for the second |
| bus_i | input | 6 | Nibble data, aligned to bit 5 |
| word_o | output | 10 | Rebuilt word |
| word_valid_o | output | 1 | One-cycle strobe for a new or repeated word |

## Verification
The bench sweeps every pair of first and second nibbles under each split and order. A design that justified a narrow nibble to bit 0 would produce wrong words there, and so would a design that let the unused low bus bits leak in or swapped the order in the wrong mode. Directed sequences open a word with several low cycles before the high one. A design that kept the oldest low nibble, or that did not repeat the held word, would show it there. Sync-high samples with no open word are also driven; a design that closed a word from stale state would emit a spurious strobe. A bus value that changes between the falling and the rising edge shows whether the selected edge really did the sampling. Bypass is swept with sync toggling, which catches any dependence on the sync level.

// File: rtl/nwa_pkg.sv
`timescale 1ns/1ps
package nwa_pkg;
   // Default geometry of the narrow transmit bus and the rebuilt word
   localparam int BUS_W_DEF  = 6;
   localparam int WORD_W_DEF = 10;

   // Word assembly phase
   typedef enum logic [0:0] {
      PH_WAIT_FIRST = 1'b0,
      PH_HAVE_FIRST = 1'b1
   } phase_t;
endpackage

// File: rtl/nwa_edge_capture.sv
`timescale 1ns/1ps
// Chooses which clock edge samples bus and sync for this path.
module nwa_edge_capture #(
   parameter int BUS_W      = 6,
   parameter bit ALLOW_FALL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             fall_sel_i,
   input  logic             sync_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             sync_o,
   output logic [BUS_W-1:0] bus_o
);
   generate
      if (ALLOW_FALL) begin : g_dual
         logic             neg_sync_q;
         logic [BUS_W-1:0] neg_bus_q;

         always_ff @(negedge clk_i) begin
            if (rst_i) begin
               neg_sync_q <= 1'b1;
               neg_bus_q  <= '0;
            end else begin
               neg_sync_q <= sync_i;
               neg_bus_q  <= bus_i;
            end
         end

         // Rising mode: the sequencer flops sample the live pins directly.
         assign sync_o = fall_sel_i ? neg_sync_q : sync_i;
         assign bus_o  = fall_sel_i ? neg_bus_q  : bus_i;
      end else begin : g_rise
         logic unused_rise;
         assign unused_rise = ^{fall_sel_i, clk_i, rst_i};
         assign sync_o = sync_i;
         assign bus_o  = bus_i;
      end
   endgenerate
endmodule

// File: rtl/nwa_nibble_pack.sv
`timescale 1ns/1ps
// Combines a held first nibble and the current second nibble into a word.
module nwa_nibble_pack #(
   parameter int BUS_W  = 6,
   parameter int WORD_W = 10
) (
   input  logic [BUS_W-1:0]  first_i,
   input  logic [BUS_W-1:0]  second_i,
   input  logic              ls_first_i,
   input  logic              even_split_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int HALF_W   = WORD_W / 2;
   localparam int NARROW_W = WORD_W - BUS_W;
   localparam int PAD_W    = WORD_W - BUS_W;

   logic [BUS_W-1:0]  ms_nib, ls_nib;
   logic [WORD_W-1:0] ms_ext, ls_ext;

   always_comb begin
      ms_nib = ls_first_i ? second_i : first_i;
      ls_nib = ls_first_i ? first_i  : second_i;
      ms_ext = {{PAD_W{1'b0}}, ms_nib};
      ls_ext = {{PAD_W{1'b0}}, ls_nib};
      if (even_split_i) begin
         // both halves are top-justified HALF_W-bit fields
         word_o = ((ms_ext >> (BUS_W - HALF_W)) << HALF_W)
                | (ls_ext >> (BUS_W - HALF_W));
      end else begin
         // full-width upper part, top-justified narrow lower part
         word_o = (ms_ext << NARROW_W)
                | (ls_ext >> (BUS_W - NARROW_W));
      end
   end
endmodule

// File: rtl/nwa_sequencer.sv
`timescale 1ns/1ps
// Tracks the sync phase, holds the first nibble and registers the output.
module nwa_sequencer
   import nwa_pkg::*;
#(
   parameter int BUS_W  = 6,
   parameter int WORD_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              bypass_i,
   input  logic              sync_i,
   input  logic [BUS_W-1:0]  bus_i,
   input  logic [WORD_W-1:0] packed_i,
   output logic [BUS_W-1:0]  first_o,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);
   localparam int PAD_W = WORD_W - BUS_W;

   phase_t            phase_q;
   logic [BUS_W-1:0]  first_q;
   logic              prev_low_q;
   logic [WORD_W-1:0] word_q;
   logic              valid_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q    <= PH_WAIT_FIRST;
         first_q    <= '0;
         prev_low_q <= 1'b0;
         word_q     <= '0;
         valid_q    <= 1'b0;
      end else if (bypass_i) begin
         word_q     <= {bus_i, {PAD_W{1'b0}}};
         valid_q    <= 1'b1;
         phase_q    <= PH_WAIT_FIRST;
         prev_low_q <= 1'b0;
      end else if (!sync_i) begin
         first_q    <= bus_i;
         phase_q    <= PH_HAVE_FIRST;
         valid_q    <= prev_low_q;
         prev_low_q <= 1'b1;
      end else begin
         prev_low_q <= 1'b0;
         if (phase_q == PH_HAVE_FIRST) begin
            word_q  <= packed_i;
            valid_q <= 1'b1;
            phase_q <= PH_WAIT_FIRST;
         end else begin
            valid_q <= 1'b0;
         end
      end
   end

   assign first_o = first_q;
   assign word_o  = word_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/nib_word_asm.sv
`timescale 1ns/1ps
module nib_word_asm #(
   parameter int BUS_W      = nwa_pkg::BUS_W_DEF,
   parameter int WORD_W     = nwa_pkg::WORD_W_DEF,
   parameter bit ALLOW_FALL = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cfg_fall_edge_i,
   input  logic              cfg_ls_first_i,
   input  logic              cfg_even_split_i,
   input  logic              cfg_bypass_i,
   input  logic              sync_i,
   input  logic [BUS_W-1:0]  bus_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o
);
   localparam int HALF_W = WORD_W / 2;

   generate
      if (WORD_W <= BUS_W || WORD_W > 2 * BUS_W) begin : g_bad_geom
         $error("nib_word_asm: WORD_W must lie in (BUS_W, 2*BUS_W]");
      end
      if ((WORD_W % 2) != 0 || HALF_W > BUS_W) begin : g_bad_half
         $error("nib_word_asm: even split needs an even WORD_W no wider than 2*BUS_W");
      end
   endgenerate

   logic              smp_sync;
   logic [BUS_W-1:0]  smp_bus;
   logic [BUS_W-1:0]  held_first;
   logic [WORD_W-1:0] packed_word;

   nwa_edge_capture #(
      .BUS_W      (BUS_W),
      .ALLOW_FALL (ALLOW_FALL)
   ) u_cap (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .fall_sel_i (cfg_fall_edge_i),
      .sync_i     (sync_i),
      .bus_i      (bus_i),
      .sync_o     (smp_sync),
      .bus_o      (smp_bus)
   );

   nwa_nibble_pack #(
      .BUS_W  (BUS_W),
      .WORD_W (WORD_W)
   ) u_pack (
      .first_i      (held_first),
      .second_i     (smp_bus),
      .ls_first_i   (cfg_ls_first_i),
      .even_split_i (cfg_even_split_i),
      .word_o       (packed_word)
   );

   nwa_sequencer #(
      .BUS_W  (BUS_W),
      .WORD_W (WORD_W)
   ) u_seq (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .bypass_i (cfg_bypass_i),
      .sync_i   (smp_sync),
      .bus_i    (smp_bus),
      .packed_i (packed_word),
      .first_o  (held_first),
      .word_o   (word_o),
      .valid_o  (word_valid_o)
   );
endmodule

// File: rtl/nwa_checker.sv
`timescale 1ns/1ps
module nwa_checker #(
   parameter int WORD_W = 10
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              cfg_fall_edge_i,
   input logic              cfg_bypass_i,
   input logic              sync_i,
   input logic [WORD_W-1:0] word_o,
   input logic              word_valid_o
);
   // Reset leaves an empty, invalid output
   assert_reset_clears_R1: assert property (@(posedge clk_i)
      rst_i |=> (!word_valid_o && word_o == '0));

   // Sync-low sample never changes the held word (rising-edge mode)
   assert_hold_word_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cfg_bypass_i && !cfg_fall_edge_i && !sync_i) |=> $stable(word_o));

   // Consecutive low samples repeat the word with a strobe
   assert_repeat_valid_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cfg_bypass_i && !cfg_fall_edge_i && !sync_i && !$past(sync_i) && !$past(rst_i))
      |=> word_valid_o);

   // Second consecutive high sample has nothing to close
   assert_no_orphan_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cfg_bypass_i && !cfg_fall_edge_i && sync_i && $past(sync_i))
      |=> !word_valid_o);

   // Bypass issues a word every cycle
   assert_bypass_valid_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      cfg_bypass_i |=> word_valid_o);
endmodule

bind nib_word_asm nwa_checker #(.WORD_W(WORD_W)) u_nwa_chk (
   .clk_i           (clk_i),
   .rst_i           (rst_i),
   .cfg_fall_edge_i (cfg_fall_edge_i),
   .cfg_bypass_i    (cfg_bypass_i),
   .sync_i          (sync_i),
   .word_o          (word_o),
   .word_valid_o    (word_valid_o)
);

// File: tb/tb_nib_word_asm.sv
`timescale 1ns/1ps
module tb_nib_word_asm;
   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       cfg_fall_edge_i = 1'b0;
   logic       cfg_ls_first_i = 1'b0;
   logic       cfg_even_split_i = 1'b0;
   logic       cfg_bypass_i = 1'b0;
   logic       sync_i = 1'b1;
   logic [5:0] bus_i = '0;
   logic [9:0] word_o;
   logic       word_valid_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nib_word_asm dut (
      .clk_i            (clk),
      .rst_i            (rst_i),
      .cfg_fall_edge_i  (cfg_fall_edge_i),
      .cfg_ls_first_i   (cfg_ls_first_i),
      .cfg_even_split_i (cfg_even_split_i),
      .cfg_bypass_i     (cfg_bypass_i),
      .sync_i           (sync_i),
      .bus_i            (bus_i),
      .word_o           (word_o),
      .word_valid_o     (word_valid_o)
   );

   // Reference arithmetic from R2/R3/R4
   function automatic logic [9:0] model(input logic [5:0] f, input logic [5:0] s,
                                        input bit lsf, input bit even);
      logic [5:0] ms, ls;
      ms = lsf ? s : f;
      ls = lsf ? f : s;
      if (even) return {ms[5:1], ls[5:1]};
      return {ms[5:0], ls[5:2]};
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [10:0] act, input logic [10:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one sample, wait for the rising edge, look just after it
   task automatic step(input logic s, input logic [5:0] b);
      sync_i = s;
      bus_i  = b;
      @(posedge clk);
      #1;
   endtask

   task automatic apply_cfg(input bit f, input bit l, input bit e, input bit b);
      rst_i = 1'b1;
      sync_i = 1'b1;
      cfg_fall_edge_i  = f;
      cfg_ls_first_i   = l;
      cfg_even_split_i = e;
      cfg_bypass_i     = b;
      repeat (2) @(posedge clk);
      #1;
      chk(word_o == '0 && !word_valid_o, "R1 reset state",
          {word_valid_o, word_o}, 11'h000);
      rst_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [9:0] prev;
      logic [9:0] exp;
      @(posedge clk);
      #1;

      // Sweep of every split/order/edge configuration
      for (int f = 0; f < 2; f++) begin
         for (int l = 0; l < 2; l++) begin
            for (int e = 0; e < 2; e++) begin
               int stride;
               stride = (f != 0) ? 9 : 1;
               apply_cfg(f[0], l[0], e[0], 1'b0);
               for (int a = 0; a < 64; a += stride) begin
                  for (int b = 0; b < 64; b += stride) begin
                     step(1'b0, 6'(a));
                     chk(!word_valid_o, "R2 no strobe on first nibble",
                         {word_valid_o, word_o}, {1'b0, word_o});
                     step(1'b1, 6'(b));
                     exp = model(6'(a), 6'(b), l[0], e[0]);
                     if (f != 0)
                        chk(word_valid_o && word_o == exp, "R9 falling-edge word",
                            {word_valid_o, word_o}, {1'b1, exp});
                     else if (e != 0)
                        chk(word_valid_o && word_o == exp, "R4 even split word",
                            {word_valid_o, word_o}, {1'b1, exp});
                     else if (l != 0)
                        chk(word_valid_o && word_o == exp, "R3 ls-first word",
                            {word_valid_o, word_o}, {1'b1, exp});
                     else
                        chk(word_valid_o && word_o == exp, "R2 default word",
                            {word_valid_o, word_o}, {1'b1, exp});
                  end
               end
            end
         end
      end

      // R6: orphan sync-high samples
      apply_cfg(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 6'h3F);
      chk(!word_valid_o && word_o == '0, "R6 high after reset",
          {word_valid_o, word_o}, 11'h000);
      step(1'b0, 6'h2A);
      step(1'b1, 6'h15);
      prev = model(6'h2A, 6'h15, 1'b0, 1'b0);
      chk(word_valid_o && word_o == prev, "R2 word before orphan",
          {word_valid_o, word_o}, {1'b1, prev});
      step(1'b1, 6'h3F);
      chk(!word_valid_o && word_o == prev, "R6 second high",
          {word_valid_o, word_o}, {1'b0, prev});

      // R7: held-low repeat, newest low nibble wins
      step(1'b0, 6'h11);
      chk(!word_valid_o && word_o == prev, "R7 first low",
          {word_valid_o, word_o}, {1'b0, prev});
      step(1'b0, 6'h22);
      chk(word_valid_o && word_o == prev, "R7 repeat 1",
          {word_valid_o, word_o}, {1'b1, prev});
      step(1'b0, 6'h33);
      chk(word_valid_o && word_o == prev, "R7 repeat 2",
          {word_valid_o, word_o}, {1'b1, prev});
      step(1'b1, 6'h0C);
      exp = model(6'h33, 6'h0C, 1'b0, 1'b0);
      chk(word_valid_o && word_o == exp, "R7 newest first nibble",
          {word_valid_o, word_o}, {1'b1, exp});

      // R5: output holds between edges
      @(negedge clk);
      #1;
      chk(word_o == exp, "R5 stable between edges", {1'b0, word_o}, {1'b0, exp});
      @(posedge clk);
      #1;

      // R9: bus changes between falling and rising edge
      for (int f = 0; f < 2; f++) begin
         apply_cfg(f[0], 1'b0, 1'b0, 1'b0);
         sync_i = 1'b0;
         bus_i  = 6'h2D;
         @(negedge clk);
         #1;
         bus_i  = 6'h12;
         @(posedge clk);
         #1;
         step(1'b1, 6'h34);
         exp = (f != 0) ? model(6'h2D, 6'h34, 1'b0, 1'b0)
                        : model(6'h12, 6'h34, 1'b0, 1'b0);
         chk(word_valid_o && word_o == exp, "R9 sampling edge",
             {word_valid_o, word_o}, {1'b1, exp});
      end

      // R8: bypass with toggling sync
      apply_cfg(1'b0, 1'b1, 1'b1, 1'b1);
      for (int v = 0; v < 64; v++) begin
         step(v[0] ^ v[3], 6'(v));
         exp = {6'(v), 4'b0000};
         chk(word_valid_o && word_o == exp, "R8 bypass word",
             {word_valid_o, word_o}, {1'b1, exp});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule